// File: doc/BRIEF.md
# Serial port register and interrupt unit

This block is the software-facing front end of a simple byte-wide serial port. A processor reaches it over a single-cycle 32-bit register bus through a small window of word offsets. Writing the data-out word sends its low byte on a byte-stream transmit interface. Bytes arriving on a byte-stream receive interface are latched into a combined data and status word together with a data-valid flag. Line serialisation and baud timing sit outside the block.

An interrupt unit keeps a raw event word, a mask, a transient acknowledge and a masked copy, and drives one level-sensitive interrupt line. Two small state machines carry the sequencing. The transmit machine has the states TXS_IDLE and TXS_PEND. A data-out write moves it from TXS_IDLE to TXS_PEND. An acknowledge with bit 0 set moves it from TXS_PEND back to TXS_IDLE, and that first acknowledge leaves the transmit-done event standing. Every other case holds the state. The receive machine has the states RXS_EMPTY and RXS_FULL. An accepted byte moves it to RXS_FULL, or keeps it there. A clearing status read with no byte arriving moves it from RXS_FULL to RXS_EMPTY. Otherwise it holds.

Offsets (bus_addr_i, byte units): 0x00 transmit config, 0x04 transmit DMA enable, 0x08 receive config, 0x1C data out, 0x20 status with clear, 0x24 status, 0x2C interrupt mask, 0x30 interrupt acknowledge, 0x34 raw events, 0x38 masked events. Status word: received byte in bits 7:0, data-valid in bit 16, transmitter-idle in bit 22, transmitter-ready in bit 24. Event bits: bit 0 is transmit-done and bit 3 is receive-available.

Top module: `uart_regif`

## Requirements
- R1: After reset the status word reads 0x0140_0000, so only bits 22 and 24 are set. Every other offset reads zero. irq_o and tx_valid_o are low and rx_ready_o is high.
- R2: Offsets 0x00, 0x04, 0x08 and 0x2C read back the last 32-bit value written to them.
- R3: Reads from unmapped or misaligned offsets return zero. Writes to them change no register, event or output.
- R4: A write with bus_full_i low is ignored. It changes no register and no event, and it produces no transmit pulse.
- R5: A full write to 0x1C drives tx_valid_o high for exactly the one cycle after the write edge, with tx_byte_o equal to wdata[7:0]. It also sets raw event bit 0.
- R6: A byte is accepted on an edge where rx_valid_i and rx_ready_o are both high. The byte then replaces status bits 7:0, status bit 16 becomes 1 and raw event bit 3 is set.
- R7: A read of 0x20 returns the status word and then clears bit 16. A read of 0x24 has no side effect. If a byte is accepted on the same edge as a clearing read, bit 16 stays set.
- R8: A write to 0x30 clears the raw event bits that are set in the written value. 0x30 always reads zero. Writes to 0x34 and 0x38 are ignored.
- R9: After a 0x1C write, the first acknowledge with bit 0 set leaves raw bit 0 set. A second such acknowledge clears it.
- R10: 0x38 reads raw AND mask, and irq_o is high exactly when that value is nonzero. Both follow a mask write on the edge of that write.
- R11: rx_ready_o equals receive-config bit 0 OR NOT raw bit 3. While it is low, an offered byte leaves the status word unchanged.
- R12: If an acknowledge that clears bit 3 is written on the same edge that a byte is accepted, raw bit 3 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | 12 | Byte offset within the window |
| bus_we_i | input | 1 | Write strobe |
| bus_full_i | input | 1 | Write is a full 32-bit access |
| bus_re_i | input | 1 | Read strobe, enables read side effects |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset |
| tx_valid_o | output | 1 | One-cycle pulse for each transmitted byte |
| tx_byte_o | output | 8 | Transmitted byte |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_byte_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte can be accepted |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are two races: an acknowledge racing a received byte, and a clearing status read racing a received byte. Each needs the receive config bit set, so that rx_ready_o stays high while event bit 3 is already set. The stimulus first sets that bit and then drives the bus and receive inputs on the same edge. The transmit re-arm needs an acknowledge sequence after a data-out write. The bench also sweeps all sixteen combinations of the two event bits and the two mask bits, and compares 0x38 and irq_o against an arithmetic AND.

// File: rtl/uart_regif_pkg.sv
`timescale 1ns/1ps
package uart_regif_pkg;
    localparam int OFF_W  = 12;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [OFF_W-1:0] OFF_TXCFG   = 12'h000;
    localparam logic [OFF_W-1:0] OFF_TXDMA   = 12'h004;
    localparam logic [OFF_W-1:0] OFF_RXCFG   = 12'h008;
    localparam logic [OFF_W-1:0] OFF_TXDATA  = 12'h01C;
    localparam logic [OFF_W-1:0] OFF_STAT_RC = 12'h020;
    localparam logic [OFF_W-1:0] OFF_STAT    = 12'h024;
    localparam logic [OFF_W-1:0] OFF_IMASK   = 12'h02C;
    localparam logic [OFF_W-1:0] OFF_IACK    = 12'h030;
    localparam logic [OFF_W-1:0] OFF_IRAW    = 12'h034;
    localparam logic [OFF_W-1:0] OFF_IMSKD   = 12'h038;

    localparam int DAV_BIT     = 16;
    localparam int TXIDLE_BIT  = 22;
    localparam int TXRDY_BIT   = 24;
    localparam int EV_TXDONE   = 0;
    localparam int EV_RXAVAIL  = 3;

    localparam int NUM_CFG     = 4;
    localparam int CFG_RX_IDX  = 2;
    localparam int CFG_MSK_IDX = 3;

    typedef enum logic {TXS_IDLE, TXS_PEND} tx_state_e;
    typedef enum logic {RXS_EMPTY, RXS_FULL} rx_state_e;
endpackage

// File: rtl/uart_regif_txfsm.sv
`timescale 1ns/1ps
module uart_regif_txfsm
    import uart_regif_pkg::*;
#(
    parameter int BYTE_W_P = BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic                ack_done_i,
    input  logic [BYTE_W_P-1:0] byte_i,
    output logic                tx_valid_o,
    output logic [BYTE_W_P-1:0] tx_byte_o,
    output logic                hold_o
);
    tx_state_e           st_q, st_d;
    logic                vld_q;
    logic [BYTE_W_P-1:0] byte_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_IDLE: if (load_i)     st_d = TXS_PEND;
            TXS_PEND: if (ack_done_i) st_d = TXS_IDLE;
            default:  st_d = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TXS_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            vld_q <= load_i;
            if (load_i) byte_q <= byte_i;
        end
    end

    always_comb begin
        hold_o     = ack_done_i && (st_q == TXS_PEND);
        tx_valid_o = vld_q;
        tx_byte_o  = byte_q;
    end

    // R9
    pend_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q == TXS_PEND));
endmodule

// File: rtl/uart_regif_rxhold.sv
`timescale 1ns/1ps
module uart_regif_rxhold
    import uart_regif_pkg::*;
#(
    parameter int BYTE_W_P = BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept_i,
    input  logic [BYTE_W_P-1:0] byte_i,
    input  logic                rd_clear_i,
    output logic                dav_o,
    output logic [BYTE_W_P-1:0] data_o
);
    rx_state_e           st_q, st_d;
    logic [BYTE_W_P-1:0] data_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RXS_EMPTY: if (accept_i) st_d = RXS_FULL;
            RXS_FULL:  if (!accept_i && rd_clear_i) st_d = RXS_EMPTY;
            default:   st_d = RXS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RXS_EMPTY;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           data_q <= '0;
        else if (accept_i) data_q <= byte_i;
    end

    always_comb begin
        dav_o  = (st_q == RXS_FULL);
        data_o = data_q;
    end

    // R6
    rx_latch_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (dav_o && data_o == $past(byte_i)));
    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clear_i && !accept_i) |=> !dav_o);
endmodule

// File: rtl/uart_regif_irq.sv
`timescale 1ns/1ps
module uart_regif_irq
    import uart_regif_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    parameter int TX_BIT   = EV_TXDONE,
    parameter int RX_BIT   = EV_RXAVAIL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_evt_i,
    input  logic                tx_set_i,
    input  logic                rx_set_i,
    input  logic                ack_wr_i,
    input  logic [WORD_W_P-1:0] ack_val_i,
    input  logic                hold_tx_i,
    input  logic [WORD_W_P-1:0] mask_i,
    output logic [WORD_W_P-1:0] raw_o,
    output logic [WORD_W_P-1:0] masked_o,
    output logic                irq_o
);
    logic [WORD_W_P-1:0] raw_q, raw_d, masked_q, masked_d, eff_ack;
    logic                irq_q;

    always_comb begin
        eff_ack = ack_wr_i ? ack_val_i : '0;
        if (hold_tx_i) eff_ack[TX_BIT] = 1'b0;
        raw_d = raw_q;
        if (tx_set_i) raw_d[TX_BIT] = 1'b1;
        raw_d = raw_d & ~eff_ack;
        if (rx_set_i) raw_d[RX_BIT] = 1'b1;
        masked_d = raw_d & mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q    <= '0;
            masked_q <= '0;
            irq_q    <= 1'b0;
        end else if (wr_evt_i || rx_set_i) begin
            raw_q    <= raw_d;
            masked_q <= masked_d;
            irq_q    <= |masked_d;
        end
    end

    always_comb begin
        raw_o    = raw_q;
        masked_o = masked_q;
        irq_o    = irq_q;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && !irq_q));
    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        hold_tx_i |=> raw_q[TX_BIT]);
    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_wr_i && !hold_tx_i && !rx_set_i) |=> ((raw_q & $past(ack_val_i)) == '0));
    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (masked_o != '0));
endmodule

// File: rtl/uart_regif.sv
`timescale 1ns/1ps
module uart_regif
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_full_i,
    input  logic              bus_re_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    output logic              rx_ready_o,
    output logic              irq_o
);
    localparam logic [NUM_CFG-1:0][OFF_W-1:0] CFG_OFFS =
        {OFF_IMASK, OFF_RXCFG, OFF_TXDMA, OFF_TXCFG};

    logic                           wr_full, dout_wr, ack_wr, rd_clear, accept, hold_tx;
    logic [NUM_CFG-1:0][WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0]              mask_next, raw, masked, stat_word;
    logic                           dav;
    logic [BYTE_W-1:0]              rx_data;

    always_comb begin
        wr_full   = bus_we_i && bus_full_i;
        dout_wr   = wr_full && (bus_addr_i == OFF_TXDATA);
        ack_wr    = wr_full && (bus_addr_i == OFF_IACK);
        rd_clear  = bus_re_i && (bus_addr_i == OFF_STAT_RC);
        mask_next = (wr_full && bus_addr_i == OFF_IMASK) ? bus_wdata_i : cfg_q[CFG_MSK_IDX];
        rx_ready_o = cfg_q[CFG_RX_IDX][0] || !raw[EV_RXAVAIL];
        accept    = rx_valid_i && rx_ready_o;
    end

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[gi] <= '0;
            else if (wr_full && bus_addr_i == CFG_OFFS[gi])
                cfg_q[gi] <= bus_wdata_i;
        end
    end

    uart_regif_txfsm #(.BYTE_W_P(BYTE_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load_i     (dout_wr),
        .ack_done_i (ack_wr && bus_wdata_i[EV_TXDONE]),
        .byte_i     (bus_wdata_i[BYTE_W-1:0]),
        .tx_valid_o (tx_valid_o),
        .tx_byte_o  (tx_byte_o),
        .hold_o     (hold_tx)
    );

    uart_regif_rxhold #(.BYTE_W_P(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .byte_i     (rx_byte_i),
        .rd_clear_i (rd_clear),
        .dav_o      (dav),
        .data_o     (rx_data)
    );

    uart_regif_irq #(.WORD_W_P(WORD_W), .TX_BIT(EV_TXDONE), .RX_BIT(EV_RXAVAIL)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .wr_evt_i  (wr_full),
        .tx_set_i  (dout_wr),
        .rx_set_i  (accept),
        .ack_wr_i  (ack_wr),
        .ack_val_i (bus_wdata_i),
        .hold_tx_i (hold_tx),
        .mask_i    (mask_next),
        .raw_o     (raw),
        .masked_o  (masked),
        .irq_o     (irq_o)
    );

    always_comb begin
        stat_word             = '0;
        stat_word[BYTE_W-1:0] = rx_data;
        stat_word[DAV_BIT]    = dav;
        stat_word[TXIDLE_BIT] = 1'b1;
        stat_word[TXRDY_BIT]  = 1'b1;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            OFF_TXCFG:   bus_rdata_o = cfg_q[0];
            OFF_TXDMA:   bus_rdata_o = cfg_q[1];
            OFF_RXCFG:   bus_rdata_o = cfg_q[CFG_RX_IDX];
            OFF_IMASK:   bus_rdata_o = cfg_q[CFG_MSK_IDX];
            OFF_STAT_RC: bus_rdata_o = stat_word;
            OFF_STAT:    bus_rdata_o = stat_word;
            OFF_IRAW:    bus_rdata_o = raw;
            OFF_IMSKD:   bus_rdata_o = masked;
            default:     bus_rdata_o = '0;
        endcase
    end

    // R5
    dout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dout_wr |=> (tx_valid_o && tx_byte_o == $past(bus_wdata_i[BYTE_W-1:0]) && raw[EV_TXDONE]));
    // R4
    narrow_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && !bus_full_i) |=> ($stable(cfg_q) && !tx_valid_o));
    // R11
    rx_block_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && !rx_ready_o) |=> $stable(rx_data));
endmodule

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        we = 1'b0, full = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [31:0] ST0 = 32'h0140_0000;

    always #10 clk = ~clk;

    uart_regif dut_i (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_we_i(we), .bus_full_i(full),
        .bus_re_i(re), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_valid_o(tx_valid), .tx_byte_o(tx_byte),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_ready_o(rx_ready), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/receive cycle, starting and ending at a falling edge.
    task automatic cyc(input logic w, input logic f, input logic r, input logic [11:0] a,
                       input logic [31:0] d, input logic rv, input logic [7:0] rb,
                       output logic [31:0] rd);
        we = w; full = f; re = r; addr = a; wdata = d; rx_valid = rv; rx_byte = rb;
        #2 rd = rdata;
        @(negedge clk);
        we = 1'b0; full = 1'b0; re = 1'b0; addr = '0; wdata = '0; rx_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] x;
        cyc(1'b1, 1'b1, 1'b0, a, d, 1'b0, 8'h00, x);
    endtask

    task automatic rdw(input logic [11:0] a, output logic [31:0] v);
        cyc(1'b0, 1'b0, 1'b1, a, 32'h0, 1'b0, 8'h00, v);
    endtask

    task automatic rxs(input logic [7:0] b);
        logic [31:0] x;
        cyc(1'b0, 1'b0, 1'b0, 12'h000, 32'h0, 1'b1, b, x);
    endtask

    task automatic clear_events();
        wr(12'h030, 32'h9);
        wr(12'h030, 32'h9);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] bad_offs [8];
        bad_offs = '{12'h00C, 12'h010, 12'h014, 12'h018, 12'h028, 12'h03C, 12'h040, 12'h002};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state across the whole window
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        for (int o = 0; o < 'h40; o += 4) begin
            rdw(o[11:0], v);
            if (o == 'h20 || o == 'h24) check("R1 status", v, ST0);
            else check("R1 zero", v, 32'h0);
        end

        // R2 plain read/write registers with several patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (32'h1 << (p * 7)) ^ (32'hA5C3_0F96 + p);
            wr(12'h000, pat);
            wr(12'h004, ~pat);
            wr(12'h008, pat & 32'hFFFF_FFFE);
            wr(12'h02C, pat & 32'hFFFF_FFF6);
            rdw(12'h000, v); check("R2 txcfg", v, pat);
            rdw(12'h004, v); check("R2 txdma", v, ~pat);
            rdw(12'h008, v); check("R2 rxcfg", v, pat & 32'hFFFF_FFFE);
            rdw(12'h02C, v); check("R2 mask", v, pat & 32'hFFFF_FFF6);
            check("R2 irq", {31'b0, irq}, 32'h0);
        end
        wr(12'h000, 32'h0000_1111);
        wr(12'h004, 32'h0000_2222);
        wr(12'h008, 32'h0);
        wr(12'h02C, 32'h0);

        // R3 unmapped offsets
        foreach (bad_offs[i]) begin
            wr(bad_offs[i], 32'hFFFF_FFFF);
            rdw(bad_offs[i], v); check("R3 unmapped read", v, 32'h0);
            check("R3 no tx", {31'b0, tx_valid}, 32'h0);
        end
        rdw(12'h000, v); check("R3 txcfg kept", v, 32'h0000_1111);
        rdw(12'h004, v); check("R3 txdma kept", v, 32'h0000_2222);
        rdw(12'h034, v); check("R3 raw kept", v, 32'h0);

        // R4 narrow writes
        cyc(1'b1, 1'b0, 1'b0, 12'h02C, 32'hFFFF_FFFF, 1'b0, 8'h0, v);
        rdw(12'h02C, v); check("R4 mask kept", v, 32'h0);
        cyc(1'b1, 1'b0, 1'b0, 12'h01C, 32'h0000_0041, 1'b0, 8'h0, v);
        check("R4 no tx", {31'b0, tx_valid}, 32'h0);
        rdw(12'h034, v); check("R4 raw kept", v, 32'h0);

        // R5 transmit sweep, R9 re-arm
        for (int b = 0; b < 256; b += 17) begin
            wr(12'h01C, {24'hA5A5A5, b[7:0]});
            check("R5 tx_valid", {31'b0, tx_valid}, 32'h1);
            check("R5 tx_byte", {24'b0, tx_byte}, {24'b0, b[7:0]});
            rdw(12'h034, v);
            check("R5 single pulse", {31'b0, tx_valid}, 32'h0);
            check("R5 raw bit0", v, 32'h1);
        end
        wr(12'h030, 32'h1);
        rdw(12'h034, v); check("R9 first ack keeps bit0", v, 32'h1);
        wr(12'h030, 32'h1);
        rdw(12'h034, v); check("R9 second ack clears bit0", v, 32'h0);

        // R10 sweep event states against mask values
        for (int ri = 0; ri < 4; ri++) begin
            for (int mi = 0; mi < 4; mi++) begin
                logic [31:0] r, m;
                r = ((ri & 1) != 0 ? 32'h1 : 32'h0) | ((ri & 2) != 0 ? 32'h8 : 32'h0);
                m = ((mi & 1) != 0 ? 32'h1 : 32'h0) | ((mi & 2) != 0 ? 32'h8 : 32'h0);
                wr(12'h02C, 32'h0);
                clear_events();
                if (r[0]) wr(12'h01C, 32'h55);
                if (r[3]) rxs(8'h10 + 8'(ri * 4 + mi));
                check("R10 no irq unmasked", {31'b0, irq}, 32'h0);
                wr(12'h02C, m);
                check("R10 irq", {31'b0, irq}, {31'b0, (r & m) != 0});
                rdw(12'h038, v); check("R10 masked", v, r & m);
                rdw(12'h034, v); check("R10 raw", v, r);
            end
        end
        wr(12'h02C, 32'h0);
        clear_events();

        // R6 / R7 receive and status reads
        rxs(8'h5A);
        rdw(12'h024, v); check("R7 plain read", v, ST0 | 32'h0001_005A);
        rdw(12'h024, v); check("R7 plain read again", v, ST0 | 32'h0001_005A);
        rdw(12'h034, v); check("R6 raw bit3", v, 32'h8);
        rdw(12'h020, v); check("R7 clear read value", v, ST0 | 32'h0001_005A);
        rdw(12'h024, v); check("R7 dav cleared", v, ST0 | 32'h0000_005A);

        // R11 receive gating
        check("R11 ready low", {31'b0, rx_ready}, 32'h0);
        rxs(8'h77);
        rdw(12'h024, v); check("R11 byte not taken", v, ST0 | 32'h0000_005A);
        wr(12'h008, 32'h1);
        check("R11 ready by config", {31'b0, rx_ready}, 32'h1);
        rxs(8'hC3);
        rdw(12'h024, v); check("R6 overwrite", v, ST0 | 32'h0001_00C3);

        // R7 clearing read racing a new byte
        cyc(1'b0, 1'b0, 1'b1, 12'h020, 32'h0, 1'b1, 8'h3C, v);
        check("R7 race read value", v, ST0 | 32'h0001_00C3);
        rdw(12'h024, v); check("R7 race dav kept", v, ST0 | 32'h0001_003C);

        // R12 acknowledge racing a new byte
        cyc(1'b1, 1'b1, 1'b0, 12'h030, 32'h8, 1'b1, 8'h99, v);
        rdw(12'h034, v); check("R12 bit3 survives", v, 32'h8);
        rdw(12'h024, v); check("R12 byte taken", v, ST0 | 32'h0001_0099);
        wr(12'h030, 32'h8);
        rdw(12'h034, v); check("R8 ack clears bit3", v, 32'h0);

        // R8 read-only and acknowledge readback
        wr(12'h01C, 32'h1);
        wr(12'h02C, 32'h1);
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h038, 32'h0);
        rdw(12'h034, v); check("R8 raw read-only", v, 32'h1);
        rdw(12'h038, v); check("R8 masked read-only", v, 32'h1);
        rdw(12'h030, v); check("R8 ack reads zero", v, 32'h0);
        check("R10 irq after mask", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule